// File: doc/BRIEF.md
# ADC Output Data Formatter

This block sits between the converter core and the output serializer. Each cycle it accepts one raw offset-binary sample with a valid flag. Instead of the sample, it can accept a test word supplied from outside. It adds a signed LSB trim to the selected word and clamps the result to the converter's code range. It can then re-code the word as two's complement and complement every bit.

The result appears on a registered output one clock later, together with a delayed copy of the valid flag. The configuration inputs are register-style levels and are normally held steady while data streams. Words are sized by `DATA_W`, default 16 bits, and the trim by `TRIM_W`, default 8 bits.

Top module: `adc_out_fmt`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next cycle shows `out_valid` = 0 and `out_data` = 0.
- R2: `out_valid` equals the `in_valid` value from the previous rising edge, so there is exactly one cycle of latency.
- R3: With test mode off, format 0 and invert 0, `out_data` is `in_data` plus the trim, where `trim` is a two's complement value (8 bits by default, -128 to +127), when that sum lies within 0 to 2^DATA_W-1.
- R4: If the sum exceeds 2^DATA_W-1, the word before formatting is all ones rather than a wrapped value.
- R5: If the sum is below 0, the word before formatting is all zeros.
- R6: `fmt_twos` = 0 gives offset binary. `fmt_twos` = 1 gives two's complement, formed by flipping the MSB (bit DATA_W-1) of the clamped offset-binary word. The default is 0.
- R7: `invert` = 1 replaces the formatted word with its bitwise complement. This is the last step before the output register.
- R8: With `test_en` = 1, `test_word` takes the place of `in_data` ahead of the trim, format and invert steps.
- R9: In a cycle with `in_valid` = 0, `out_data` keeps its previous value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | DATA_W | Raw offset-binary sample |
| test_en | input | 1 | Select test word instead of sample |
| test_word | input | DATA_W | Substitute word used in test mode |
| trim | input | TRIM_W | Signed offset trim in LSBs |
| fmt_twos | input | 1 | 0 = offset binary, 1 = two's complement |
| invert | input | 1 | Complement the formatted word |
| out_valid | output | 1 | Registered valid flag |
| out_data | output | DATA_W | Registered formatted word |

## Verification
The assertions assume that the configuration inputs, `test_word` and `trim` are ordinary levels sampled on the same edge as `in_valid`. They also assume `in_valid` is low throughout reset. The stimulus changes every input only on the falling clock edge and keeps `in_valid` low while `rst` is high. It sweeps every sample, trim value, format and invert setting of a narrow 8-bit data, 4-bit trim configuration, which reaches both clamp boundaries on every path.

// File: rtl/adc_out_fmt_pkg.sv
package adc_out_fmt_pkg;
  typedef enum logic {
    FMT_OFFSET_BIN = 1'b0,
    FMT_TWOS_COMP  = 1'b1
  } out_fmt_e;
endpackage

// File: rtl/adc_fmt_src_sel.sv
module adc_fmt_src_sel #(
  parameter int DATA_W = 16
) (
  input  logic              test_en,
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] test_word,
  output logic [DATA_W-1:0] src
);
  always_comb begin
    src = test_en ? test_word : sample;
  end
endmodule

// File: rtl/adc_fmt_trim_sat.sv
module adc_fmt_trim_sat #(
  parameter int DATA_W = 16,
  parameter int TRIM_W = 8
) (
  input  logic [DATA_W-1:0] src,
  input  logic [TRIM_W-1:0] trim,
  output logic [DATA_W-1:0] clamped
);
  localparam int SUM_W = DATA_W + 2;
  localparam int EXT_W = SUM_W - TRIM_W;

  logic [SUM_W-1:0] src_ext;
  logic [SUM_W-1:0] trim_ext;
  logic [SUM_W-1:0] sum;

  always_comb begin
    src_ext  = {2'b00, src};
    trim_ext = {{EXT_W{trim[TRIM_W-1]}}, trim};
    sum      = src_ext + trim_ext;
    if (sum[SUM_W-1]) begin
      clamped = '0;
    end else if (sum[DATA_W]) begin
      clamped = '1;
    end else begin
      clamped = sum[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/adc_fmt_code_conv.sv
module adc_fmt_code_conv
  import adc_out_fmt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              fmt_twos,
  input  logic              invert,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] word_out
);
  out_fmt_e          fmt;
  logic [DATA_W-1:0] coded;

  always_comb begin
    fmt   = out_fmt_e'(fmt_twos);
    coded = word_in;
    if (fmt == FMT_TWOS_COMP) begin
      coded[DATA_W-1] = ~word_in[DATA_W-1];
    end
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_inv
    assign word_out[b] = coded[b] ^ invert;
  end
endmodule

// File: rtl/adc_out_fmt.sv
module adc_out_fmt #(
  parameter int DATA_W = 16,
  parameter int TRIM_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              test_en,
  input  logic [DATA_W-1:0] test_word,
  input  logic [TRIM_W-1:0] trim,
  input  logic              fmt_twos,
  input  logic              invert,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] clamped;
  logic [DATA_W-1:0] formatted;

  adc_fmt_src_sel #(.DATA_W(DATA_W)) u_src (
    .test_en   (test_en),
    .sample    (in_data),
    .test_word (test_word),
    .src       (src)
  );

  adc_fmt_trim_sat #(.DATA_W(DATA_W), .TRIM_W(TRIM_W)) u_trim (
    .src     (src),
    .trim    (trim),
    .clamped (clamped)
  );

  adc_fmt_code_conv #(.DATA_W(DATA_W)) u_conv (
    .fmt_twos (fmt_twos),
    .invert   (invert),
    .word_in  (clamped),
    .word_out (formatted)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= formatted;
      end
    end
  end
endmodule

// File: rtl/adc_out_fmt_chk.sv
module adc_out_fmt_chk #(
  parameter int DATA_W = 16,
  parameter int TRIM_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              test_en,
  input logic [DATA_W-1:0] test_word,
  input logic [TRIM_W-1:0] trim,
  input logic              fmt_twos,
  input logic              invert,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);
  logic plain_cfg;
  assign plain_cfg = !fmt_twos && !invert;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  p_valid_on_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_off_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_sat_hi_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !test_en && plain_cfg && in_data == '1 && !trim[TRIM_W-1])
      |=> out_data == '1);

  p_sat_lo_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !test_en && plain_cfg && in_data == '0 && trim[TRIM_W-1])
      |=> out_data == '0);

  p_test_sel_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && test_en && plain_cfg && trim == '0)
      |=> out_data == $past(test_word));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));
endmodule

bind adc_out_fmt adc_out_fmt_chk #(.DATA_W(DATA_W), .TRIM_W(TRIM_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .test_en   (test_en),
  .test_word (test_word),
  .trim      (trim),
  .fmt_twos  (fmt_twos),
  .invert    (invert),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/adc_out_fmt_bench.sv
module adc_out_fmt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int TW = 4;
  localparam int MAXC = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          test_en = 1'b0;
  logic [DW-1:0] test_word = '0;
  logic [TW-1:0] trim = '0;
  logic          fmt_twos = 1'b0;
  logic          invert = 1'b0;
  logic          out_valid;
  logic [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_out_fmt #(.DATA_W(DW), .TRIM_W(TW)) u_adc_out_fmt (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .test_en(test_en), .test_word(test_word), .trim(trim),
    .fmt_twos(fmt_twos), .invert(invert),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic int model(int src, int t, bit f, bit inv, output string tag);
    int s;
    s = src + t;
    tag = "R3";
    if (s > MAXC) begin s = MAXC; tag = "R4"; end
    if (s < 0)    begin s = 0;    tag = "R5"; end
    if (f)   begin s = s ^ (1 << (DW-1)); tag = {tag, "/R6"}; end
    if (inv) begin s = MAXC - s;          tag = {tag, "/R7"}; end
    return s;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(bit v, int d, bit tm, int tw, int t, bit f, bit inv);
    string tag;
    int exp_d;
    int prev;
    prev = int'(out_data);
    in_valid  = v;
    in_data   = DW'(d);
    test_en   = tm;
    test_word = DW'(tw);
    trim      = TW'(t);
    fmt_twos  = f;
    invert    = inv;
    exp_d = model(tm ? tw : d, t, f, inv, tag);
    if (tm) tag = {"R8/", tag};
    @(posedge clk);
    @(negedge clk);
    check("R2", int'(out_valid), int'(v));
    if (v) check(tag, int'(out_data), exp_d);
    else   check("R9", int'(out_data), prev);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_data), 0);
    rst = 1'b0;

    // R3 R4 R5 R6 R7: exhaustive sweep of sample, trim, format, invert
    for (int c = 0; c < 4; c++) begin
      for (int t = -(1 << (TW-1)); t < (1 << (TW-1)); t++) begin
        for (int d = 0; d <= MAXC; d++) begin
          apply(1'b1, d, 1'b0, 0, t, c[0], c[1]);
        end
      end
    end

    // R8: test word replaces the sample
    for (int w = 0; w <= MAXC; w++) begin
      apply(1'b1, MAXC - w, 1'b1, w, 0, 1'b0, 1'b0);
      apply(1'b1, w, 1'b1, w ^ 8'h5A, (w % 16) - 8, w[0], w[1]);
    end

    // R9 and R2: invalid cycles keep the output word
    apply(1'b1, 8'h3C, 1'b0, 0, 0, 1'b0, 1'b0);
    for (int k = 0; k < 32; k++) begin
      apply(1'b0, k * 7, k[0], k * 3, (k % 16) - 8, k[1], k[2]);
    end

    // R1: reset mid-stream clears the output
    apply(1'b1, 8'hF0, 1'b0, 0, 0, 1'b0, 1'b0);
    rst = 1'b1;
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_data), 0);
    rst = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule